// File: doc/BRIEF.md
# Shared-Address I2C Display Memory Slave

This block is the serial front end of a cascadable display controller. Several such devices sit on one two-wire bus under the same 7-bit address. Each one tells itself apart from the others by a 4-bit hardware subaddress strap. The bus pins are oversampled by the system clock. The block drives SDA only through an open-drain enable and moves bytes to and from an external 64-byte display memory port.

A write transfer opens with a chain of command bytes. Every device that matches the address acknowledges them. Commands load a shared data pointer and a shared subaddress counter. Once the chain ends, each byte is a data byte. Only the device whose strap equals the subaddress counter acknowledges a data byte and stores it. Every device still advances its pointer, so one stream of bytes fills one device after another.

A read transfer streams memory bytes out, MSB first, starting at the pointer. It goes on until the master withholds acknowledge.

Top module: `disp_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper six bits are 011110 and whose seventh bit equals `addr_sel_i`. The last bit of the address byte is R/W, where 1 means read.
- R2: If the address does not match, the block leaves SDA released for the rest of that transfer, writes nothing and leaves the pointer unchanged.
- R3: In a write, every command byte is acknowledged, whatever the subaddress strap is.
- R4: Bit 7 of a command byte is the continuation flag. When it is 1, another command follows. When it is 0, every later byte of the transfer is a data byte.
- R5: A command with bits 6:4 = 111 loads the subaddress counter from bits 3:0. A command with bit 6 = 0 loads the pointer from bits 5:0. Any other command changes neither.
- R6: A data byte is written to memory at the pointer, and acknowledged, only when the subaddress counter equals `subaddr_i`. Otherwise SDA stays released and nothing is written.
- R7: After every data byte, whether written or not, the pointer advances by one. When it passes 63 it wraps to 0 and the subaddress counter increments modulo 16.
- R8: In a read, after the address acknowledge, the block shifts out the byte at the pointer MSB first, then advances the pointer as in R7. It drives SDA only when the subaddress counter equals `subaddr_i`; otherwise the master reads 0xFF.
- R9: While the master acknowledges, reading continues with the next byte. After a master NACK, the block keeps SDA released until the next START.
- R10: A repeated START returns the block to address reception, and the byte after the new address is a command. A STOP returns it to idle. The pointer and subaddress counter keep their values across transfers.
- R11: `sda_oe` changes only while SCL is low.
- R12: After reset, SDA is released, no write is pending, and the pointer and subaddress counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, pull SDA low |
| addr_sel_i | input | 1 | Strap for the address LSB |
| subaddr_i | input | 4 | Hardware subaddress strap |
| ram_wr_en | output | 1 | One-cycle memory write strobe |
| ram_wr_addr | output | 6 | Memory write address |
| ram_wr_data | output | 8 | Memory write data |
| ram_rd_addr | output | 6 | Memory read address (the pointer) |
| ram_rd_data | input | 8 | Memory read data, combinational from `ram_rd_addr` |

## Verification
SCL and SDA pass through two synchronizer stages and an edge register, so every reaction of the block lands about three clocks after the bus edge that causes it. That covers acknowledge drive, release, the next read bit and the memory write strobe. The bench holds each SCL phase for ten clocks and samples SDA in the middle of the high phase, well after that latency and well before the next edge. Memory contents and the pointer are checked only after a STOP, when all writes have settled. The rule that SDA changes only while SCL is low is watched on every clock for the whole run.

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave #(
  parameter int PTR_W = 6,
  parameter int SUB_W = 4,
  parameter logic [5:0] ADDR_HI = 6'b011110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             addr_sel_i,
  input  logic [SUB_W-1:0] subaddr_i,
  output logic             ram_wr_en,
  output logic [PTR_W-1:0] ram_wr_addr,
  output logic [7:0]       ram_wr_data,
  output logic [PTR_W-1:0] ram_rd_addr,
  input  logic [7:0]       ram_rd_data
);
  localparam int LOC_W = PTR_W + SUB_W;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_ACK, S_TX, S_RACK} st_t;

  st_t              st, nxt;
  logic [2:0]       scl_sr, sda_sr;
  logic [7:0]       sh;
  logic [3:0]       cnt;
  logic [LOC_W-1:0] loc;
  logic             ack_en, tx_en, mnack;

  wire scl_s    = scl_sr[1];
  wire scl_p    = scl_sr[2];
  wire sda_s    = sda_sr[1];
  wire sda_p    = sda_sr[2];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire sub_hit  = (loc[LOC_W-1:PTR_W] == subaddr_i);

  assign ram_rd_addr = loc[PTR_W-1:0];
  assign sda_oe = ((st == S_ACK) && ack_en) || ((st == S_TX) && tx_en && !sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr      <= '1;
      sda_sr      <= '1;
      st          <= S_IDLE;
      nxt         <= S_IDLE;
      sh          <= '0;
      cnt         <= '0;
      loc         <= '0;
      ack_en      <= 1'b0;
      tx_en       <= 1'b0;
      mnack       <= 1'b0;
      ram_wr_en   <= 1'b0;
      ram_wr_addr <= '0;
      ram_wr_data <= '0;
    end else begin
      scl_sr    <= {scl_sr[1:0], scl_i};
      sda_sr    <= {sda_sr[1:0], sda_i};
      ram_wr_en <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        ack_en <= 1'b0;
        tx_en  <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        ack_en <= 1'b0;
        tx_en  <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_DATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              st  <= S_ACK;
              if (st == S_ADDR) begin
                if (sh[7:1] == {ADDR_HI, addr_sel_i}) begin
                  ack_en <= 1'b1;
                  nxt    <= sh[0] ? S_TX : S_CMD;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_CMD) begin
                ack_en <= 1'b1;
                nxt    <= sh[7] ? S_CMD : S_DATA;
                if (sh[6:4] == 3'b111)
                  loc[LOC_W-1:PTR_W] <= sh[SUB_W-1:0];
                else if (!sh[6])
                  loc[PTR_W-1:0] <= sh[PTR_W-1:0];
              end else begin
                ack_en <= sub_hit;
                nxt    <= S_DATA;
                if (sub_hit) begin
                  ram_wr_en   <= 1'b1;
                  ram_wr_addr <= loc[PTR_W-1:0];
                  ram_wr_data <= sh;
                end
                loc <= loc + LOC_W'(1);
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              ack_en <= 1'b0;
              cnt    <= '0;
              st     <= nxt;
              if (nxt == S_TX) begin
                sh    <= ram_rd_data;
                tx_en <= sub_hit;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                st    <= S_RACK;
                tx_en <= 1'b0;
                loc   <= loc + LOC_W'(1);
              end else begin
                sh <= {sh[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              if (mnack) begin
                st <= S_IDLE;
              end else begin
                st    <= S_TX;
                cnt   <= '0;
                sh    <= ram_rd_data;
                tx_en <= sub_hit;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module disp_i2c_slave_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             scl_p,
  input logic             sda_oe,
  input logic             ram_wr_en,
  input logic [PTR_W-1:0] ram_wr_addr,
  input logic [PTR_W-1:0] ram_rd_addr
);
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p) |-> $stable(sda_oe));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |=> !ram_wr_en);

  assert_wr_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> sda_oe);

  assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (ram_rd_addr == ram_wr_addr + PTR_W'(1)));
endmodule

bind disp_i2c_slave disp_i2c_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .scl_s(scl_sr[1]),
  .scl_p(scl_sr[2]),
  .sda_oe(sda_oe),
  .ram_wr_en(ram_wr_en),
  .ram_wr_addr(ram_wr_addr),
  .ram_rd_addr(ram_rd_addr)
);

// File: tb/disp_i2c_slave_tb.sv
`timescale 1ns/1ps
module disp_i2c_slave_tb_top;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic       addr_sel = 1'b0;
  logic [3:0] strap = 4'd0;
  logic       ram_wr_en;
  logic [5:0] ram_wr_addr, ram_rd_addr;
  logic [7:0] ram_wr_data, ram_rd_data;
  logic [7:0] mem [64];

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  bit done = 1'b0;
  logic scl_q = 1'b1;
  logic oe_q = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign ram_rd_data = mem[ram_rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (ram_wr_en) begin
      mem[ram_wr_addr] <= ram_wr_data;
    end
  end

  disp_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel_i(addr_sel), .subaddr_i(strap),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data)
  );

  // R11 monitor: enable must hold while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_q && (sda_oe !== oe_q)) oe_viol++;
    scl_q = scl_m;
    oe_q  = sda_oe;
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    ack = !sda_bus;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0; hp();
  endtask

  task automatic recv(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1;
      repeat (HALF/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (HALF/2) @(negedge clk);
      scl_m = 1'b0;
    end
    hp(); sda_m = mack ? 1'b0 : 1'b1;
    hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    check("R12 sda_oe", sda_oe, 0);
    check("R12 ram_wr_en", ram_wr_en, 0);
    check("R12 pointer", ram_rd_addr, 0);
  endtask

  task automatic t_address();
    logic a;
    addr_sel = 1'b0;
    bus_start(); send(8'h7A, a); check("R2 foreign address nack", a, 0);
    send(8'h8A, a); check("R2 byte after foreign address", a, 0);
    bus_stop(); check("R2 pointer untouched", ram_rd_addr, 0);
    bus_start(); send(8'h78, a); check("R1 address ack sel0", a, 1); bus_stop();
    addr_sel = 1'b1;
    bus_start(); send(8'h7A, a); check("R1 address ack sel1", a, 1); bus_stop();
    bus_start(); send(8'h78, a); check("R2 address nack sel1", a, 0); bus_stop();
    addr_sel = 1'b0;
  endtask

  task automatic t_cmd_chain();
    logic a;
    strap = 4'd5;
    bus_start(); send(8'h78, a);
    send(8'hF5, a); check("R3 command ack sub", a, 1);
    send(8'h8A, a); check("R3 command ack ptr", a, 1);
    send(8'hC3, a); check("R5 ignored command ack", a, 1);
    send(8'h40, a); check("R4 last command ack", a, 1);
    send(8'h11, a); check("R6 data ack", a, 1);
    send(8'h22, a); check("R6 data ack 2", a, 1);
    bus_stop();
    check("R4 R5 first data at ptr 10", mem[10], 8'h11);
    check("R7 second data at ptr 11", mem[11], 8'h22);
    check("R7 pointer after two", ram_rd_addr, 12);
  endtask

  task automatic t_wrap();
    logic a;
    strap = 4'd5;
    bus_start(); send(8'h78, a); send(8'hF4, a); send(8'h3E, a);
    send(8'hA1, a); check("R6 mismatch nack", a, 0);
    send(8'hA2, a); check("R6 mismatch nack 2", a, 0);
    send(8'hA3, a); check("R7 after wrap ack", a, 1);
    send(8'hA4, a); check("R7 after wrap ack 2", a, 1);
    bus_stop();
    check("R6 no write at 62", mem[62], init_val(62));
    check("R6 no write at 63", mem[63], init_val(63));
    check("R7 wrapped to 0", mem[0], 8'hA3);
    check("R7 wrapped to 1", mem[1], 8'hA4);
    check("R7 pointer after wrap", ram_rd_addr, 2);
  endtask

  task automatic t_sub_mod16();
    logic a;
    strap = 4'd0;
    bus_start(); send(8'h78, a); send(8'hFF, a); send(8'h3F, a);
    send(8'h5A, a); check("R6 sub 15 nack", a, 0);
    send(8'h5B, a); check("R7 sub wraps to 0 ack", a, 1);
    bus_stop();
    check("R7 sub wrap data", mem[0], 8'h5B);
    check("R6 sub 15 not written", mem[63], init_val(63));
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    bit hi_ok;
    strap = 4'd0;
    bus_start(); send(8'h78, a); send(8'h00, a); bus_stop();
    bus_start(); send(8'h79, a); check("R1 read address ack", a, 1);
    recv(d, 1'b1); check("R8 read byte 0", d, 8'h5B);
    recv(d, 1'b1); check("R9 read byte 1", d, 8'hA4);
    recv(d, 1'b0); check("R9 read byte 2", d, init_val(2));
    hi_ok = 1'b1;
    for (int k = 0; k < 9; k++) begin
      hp(); scl_m = 1'b1;
      repeat (HALF/2) @(negedge clk);
      if (sda_bus !== 1'b1) hi_ok = 1'b0;
      repeat (HALF/2) @(negedge clk);
      scl_m = 1'b0;
    end
    hp();
    check("R9 released after nack", hi_ok, 1);
    bus_stop();
    check("R8 pointer after read", ram_rd_addr, 3);
  endtask

  task automatic t_read_other();
    logic a;
    logic [7:0] d;
    strap = 4'd0;
    bus_start(); send(8'h78, a); send(8'h73, a); check("R5 sub load C=0 ack", a, 1); bus_stop();
    bus_start(); send(8'h79, a);
    recv(d, 1'b0); check("R8 other sub reads ff", d, 8'hFF);
    bus_stop();
    check("R8 pointer advances on other sub", ram_rd_addr, 4);
  endtask

  task automatic t_restart();
    logic a;
    strap = 4'd0;
    bus_start(); send(8'h78, a); send(8'hF0, a); send(8'h14, a);
    send(8'h66, a); check("R6 data at 20 ack", a, 1);
    bus_start(); send(8'h78, a); check("R10 restart address ack", a, 1);
    send(8'h19, a); check("R10 byte after restart is command", a, 1);
    send(8'h77, a);
    bus_stop();
    check("R10 data before restart", mem[20], 8'h66);
    check("R10 command moved pointer", mem[25], 8'h77);
    check("R10 no data at 21", mem[21], init_val(21));
    bus_start(); send(8'h78, a); send(8'h70, a); send(8'h88, a); bus_stop();
    check("R10 pointer kept across transfers", mem[26], 8'h88);
    check("R10 final pointer", ram_rd_addr, 27);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (10) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_address();
    t_cmd_chain();
    t_wrap();
    t_sub_mod16();
    t_read();
    t_read_other();
    t_restart();
    check("R11 oe stable while SCL high", oe_viol, 0);
    finish_run();
  end
endmodule